// File: doc/BRIEF.md
# Register-Bus Serial Port with Interrupt Enables

This block is a serial port for a simple 32-bit memory-mapped register bus. It holds one outgoing character in a holding register and one received character in a receive buffer. It shifts frames out and in with 8 data bits, no parity and one stop bit. The bit period is a programmable number of core clocks.

Software reads a status word that carries per-event flags. A control word uses the same bit positions as interrupt enables, and the single interrupt output is raised whenever an enabled flag is set. The error flags are sticky: they are cleared by writing any value to the status word, and a summary bit rises with any of them. The control word also carries two spare bits, one to drive the RTS output and one to hold the transmit line in a break. The CTS input is synchronised and reported together with a change flag.

Accesses are word-aligned byte addresses inside a 32-byte window. Reads are combinational. A read strobe on the receive data word consumes the held character.

Top module: `regbus_uart`

## Requirements
- R1: After reset the status word reads 0x060 (transmit ready at bit 6 and shifter empty at bit 5) with CTS low. Control reads 0, the divisor reads its reset value, irq is low, txd is high and rts is low.
- R2: Word addresses are: receive data at 0x00, transmit data at 0x04, status at 0x08, control at 0x0C and divisor at 0x10. Every other address in the window, including 0x14, reads 0 and ignores writes.
- R3: Each transmitted frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts the divisor value in clocks, and a divisor below 4 acts as 4.
- R4: Transmit ready (bit 6) is high when the holding register is free. Shifter empty (bit 5) is high only when nothing is held and nothing is being shifted, and txd is then idle high.
- R5: A write to transmit data while transmit ready is low is dropped and sets transmit overrun (bit 4).
- R6: The receiver samples each bit at mid-period after a three-flop synchroniser. A completed frame sets receive ready (bit 7) and loads the receive data word. Reading receive data clears receive ready.
- R7: A frame that completes while receive ready is still set sets receive overrun (bit 3) and replaces the held character.
- R8: A 0 stop bit sets framing error (bit 1). A frame whose data and stop bits are all 0 sets break (bit 2) as well.
- R9: The exception bit (bit 8) is the OR of bits 0 to 4. Bit 0 (parity error) is never set, because no parity is used.
- R10: Any write to the status word clears bits 0 to 4, bit 8 and bit 10. An event in the same cycle as the clear still sets its flag.
- R11: irq is the OR of (status AND control) over positions 0 to 8, 10 and 12 only. With control at 0, irq is low.
- R12: Control bit 9 forces txd low. Control bit 11 drives rts.
- R13: Status bit 11 shows CTS after two synchronising flops and one more register. Bit 10 is set on each change of that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on address |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts | output | 1 | Request-to-send output |
| cts | input | 1 | Clear-to-send input |

## Verification
The assertions check these relations on every cycle:
- txd is high whenever the shifter is empty and no break is forced, and low while a break is forced.
- A transmit write while the port is not ready leaves the overrun flag set.
- A receive read without a completing frame clears receive ready.
- A status write leaves the error flags clear.
- A frame that completes while receive ready is set raises receive overrun.
- irq stays low while control is zero.

The exact frame shapes can only be shown by the bench's scenarios. Those are the bit order and bit timing over all 256 character values in both directions, the divisor clamp, framing and break detection, and the CTS change path.

// File: rtl/regbus_uart_pkg.sv
// Shared constants for the register-bus serial port.
// Assumes word-aligned byte addresses inside a 32-byte window.
package regbus_uart_pkg;
    localparam int unsigned WORD_RX   = 0;
    localparam int unsigned WORD_TX   = 1;
    localparam int unsigned WORD_STAT = 2;
    localparam int unsigned WORD_CTRL = 3;
    localparam int unsigned WORD_DIV  = 4;

    localparam int unsigned STAT_W  = 13;
    localparam int unsigned B_PAR   = 0;
    localparam int unsigned B_FRM   = 1;
    localparam int unsigned B_BRK   = 2;
    localparam int unsigned B_ROVR  = 3;
    localparam int unsigned B_TOVR  = 4;
    localparam int unsigned B_TEMP  = 5;
    localparam int unsigned B_TRDY  = 6;
    localparam int unsigned B_RRDY  = 7;
    localparam int unsigned B_EXC   = 8;
    localparam int unsigned B_TBRK  = 9;
    localparam int unsigned B_DCTS  = 10;
    localparam int unsigned B_CTS   = 11;
    localparam int unsigned B_PKT   = 12;

    localparam logic [STAT_W-1:0] IRQ_POS_MASK = 13'h15FF;

    typedef enum logic [2:0] {
        RXS_IDLE, RXS_START, RXS_DATA, RXS_STOP, RXS_WAITHI
    } rx_state_e;
endpackage

// File: rtl/uart_txer.sv
// Transmit path: one-character holding register feeding a frame shifter.
// Assumes wr_stb is a single-cycle strobe; divisors below 4 act as 4.
module uart_txer #(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic [DIV_W-1:0]     div,
    output logic                 ser_out,
    output logic                 hold_free,
    output logic                 all_empty,
    output logic                 ovr_pulse
);
    localparam int FRAME = DATA_BITS + 2;
    localparam int CNT_W = $clog2(FRAME + 1);

    logic [DATA_BITS-1:0] hold_q;
    logic                 hold_full;
    logic                 busy;
    logic [FRAME-1:0]     shreg;
    logic [CNT_W-1:0]     left;
    logic [DIV_W-1:0]     tcnt;
    logic [DIV_W-1:0]     div_eff;

    assign div_eff = (div < DIV_W'(4)) ? DIV_W'(4) : div;

    // Holding register: accepts a character when free, hands it to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (wr_stb && !hold_full) begin
            hold_full <= 1'b1;
            hold_q    <= wr_data;
        end else if (hold_full && !busy) begin
            hold_full <= 1'b0;
        end
    end

    // Frame shifter: start bit, data LSB first, stop bit, div_eff clocks each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            tcnt  <= '0;
        end else if (!busy) begin
            if (hold_full) begin
                busy  <= 1'b1;
                shreg <= {1'b1, hold_q, 1'b0};
                left  <= CNT_W'(FRAME);
                tcnt  <= div_eff - 1'b1;
            end
        end else if (tcnt == '0) begin
            shreg <= {1'b1, shreg[FRAME-1:1]};
            tcnt  <= div_eff - 1'b1;
            left  <= left - 1'b1;
            if (left == CNT_W'(1)) busy <= 1'b0;
        end else begin
            tcnt <= tcnt - 1'b1;
        end
    end

    assign ser_out   = busy ? shreg[0] : 1'b1;
    assign hold_free = !hold_full;
    assign all_empty = !hold_full && !busy;
    assign ovr_pulse = wr_stb && hold_full;
endmodule

// File: rtl/uart_rxer.sv
// Receive path: three-flop synchroniser and a mid-bit sampling frame decoder.
// Assumes divisors below 4 act as 4; after a 0 stop bit waits for an idle line.
module uart_rxer
    import regbus_uart_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    input  logic [DIV_W-1:0]     div,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 stop_bad,
    output logic                 all_zero
);
    localparam int IDX_W = $clog2(DATA_BITS);

    logic [2:0]           sync_q;
    logic                 line;
    rx_state_e            state;
    logic [DIV_W-1:0]     tcnt;
    logic [DIV_W-1:0]     div_eff;
    logic [IDX_W-1:0]     bidx;
    logic [DATA_BITS-1:0] shreg;

    assign div_eff = (div < DIV_W'(4)) ? DIV_W'(4) : div;
    assign line    = sync_q[2];

    // Synchroniser for the asynchronous serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[1:0], ser_in};
    end

    // Frame decoder: confirms the start bit at mid-period, then samples each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RXS_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            done     <= 1'b0;
            data     <= '0;
            stop_bad <= 1'b0;
            all_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RXS_IDLE: if (!line) begin
                    state <= RXS_START;
                    tcnt  <= (div_eff >> 1) - 1'b1;
                end
                RXS_START: if (tcnt == '0) begin
                    state <= line ? RXS_IDLE : RXS_DATA;
                    tcnt  <= div_eff - 1'b1;
                    bidx  <= '0;
                end else tcnt <= tcnt - 1'b1;
                RXS_DATA: if (tcnt == '0) begin
                    shreg <= {line, shreg[DATA_BITS-1:1]};
                    tcnt  <= div_eff - 1'b1;
                    if (bidx == IDX_W'(DATA_BITS - 1)) state <= RXS_STOP;
                    else bidx <= bidx + 1'b1;
                end else tcnt <= tcnt - 1'b1;
                RXS_STOP: if (tcnt == '0) begin
                    done     <= 1'b1;
                    data     <= shreg;
                    stop_bad <= !line;
                    all_zero <= !line && (shreg == '0);
                    state    <= line ? RXS_IDLE : RXS_WAITHI;
                end else tcnt <= tcnt - 1'b1;
                RXS_WAITHI: if (line) state <= RXS_IDLE;
                default: state <= RXS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regbus_uart.sv
// Top: register file, sticky status flags, interrupt combine, modem lines.
// Assumes single-cycle bus strobes and word-aligned addresses; reads are combinational.
module regbus_uart
    import regbus_uart_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        txd,
    input  logic        rxd,
    output logic        rts,
    input  logic        cts
);
    logic [2:0]           word;
    logic                 aligned;
    logic                 wr_tx, wr_stat, wr_ctrl, wr_div, rd_rx;
    logic [STAT_W-1:0]    ctrl_q;
    logic [DIV_W-1:0]     div_q;
    logic [DATA_BITS-1:0] rx_buf;
    logic                 rrdy_q, frm_q, brk_q, rovr_q, tovr_q, dcts_q;
    logic [1:0]           cts_sync;
    logic                 cts_q;
    logic                 tx_ser, tx_free, tx_empty, tx_ovr;
    logic                 rx_done, rx_stop_bad, rx_zero;
    logic [DATA_BITS-1:0] rx_data;
    logic [STAT_W-1:0]    stat_vec;

    assign word    = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_tx   = bus_wr && aligned && (word == 3'(WORD_TX));
    assign wr_stat = bus_wr && aligned && (word == 3'(WORD_STAT));
    assign wr_ctrl = bus_wr && aligned && (word == 3'(WORD_CTRL));
    assign wr_div  = bus_wr && aligned && (word == 3'(WORD_DIV));
    assign rd_rx   = bus_rd && aligned && (word == 3'(WORD_RX));

    uart_txer #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_tx),
        .wr_data(bus_wdata[DATA_BITS-1:0]), .div(div_q),
        .ser_out(tx_ser), .hold_free(tx_free), .all_empty(tx_empty),
        .ovr_pulse(tx_ovr)
    );

    uart_rxer #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_in(rxd), .div(div_q),
        .done(rx_done), .data(rx_data), .stop_bad(rx_stop_bad),
        .all_zero(rx_zero)
    );

    // Control and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= DIV_W'(DIV_RESET);
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[STAT_W-1:0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    // Receive buffer and receive-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
            rrdy_q <= 1'b0;
        end else if (rx_done) begin
            rx_buf <= rx_data;
            rrdy_q <= 1'b1;
        end else if (rd_rx) begin
            rrdy_q <= 1'b0;
        end
    end

    // CTS synchroniser and registered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_sync <= '0;
            cts_q    <= 1'b0;
        end else begin
            cts_sync <= {cts_sync[0], cts};
            cts_q    <= cts_sync[1];
        end
    end

    // Sticky flags: a status write clears them, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q  <= 1'b0;
            brk_q  <= 1'b0;
            rovr_q <= 1'b0;
            tovr_q <= 1'b0;
            dcts_q <= 1'b0;
        end else begin
            frm_q  <= (frm_q  && !wr_stat) || (rx_done && rx_stop_bad);
            brk_q  <= (brk_q  && !wr_stat) || (rx_done && rx_zero);
            rovr_q <= (rovr_q && !wr_stat) || (rx_done && rrdy_q && !rd_rx);
            tovr_q <= (tovr_q && !wr_stat) || tx_ovr;
            dcts_q <= (dcts_q && !wr_stat) || (cts_sync[1] ^ cts_q);
        end
    end

    // Status word assembly.
    always_comb begin
        stat_vec         = '0;
        stat_vec[B_FRM]  = frm_q;
        stat_vec[B_BRK]  = brk_q;
        stat_vec[B_ROVR] = rovr_q;
        stat_vec[B_TOVR] = tovr_q;
        stat_vec[B_TEMP] = tx_empty;
        stat_vec[B_TRDY] = tx_free;
        stat_vec[B_RRDY] = rrdy_q;
        stat_vec[B_EXC]  = frm_q || brk_q || rovr_q || tovr_q;
        stat_vec[B_DCTS] = dcts_q;
        stat_vec[B_CTS]  = cts_q;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (word)
                3'(WORD_RX):   bus_rdata = 32'(rx_buf);
                3'(WORD_STAT): bus_rdata = 32'(stat_vec);
                3'(WORD_CTRL): bus_rdata = 32'(ctrl_q);
                3'(WORD_DIV):  bus_rdata = 32'(div_q);
                default:       bus_rdata = '0;
            endcase
        end
    end

    assign irq = |(stat_vec & ctrl_q & IRQ_POS_MASK);
    assign txd = ctrl_q[B_TBRK] ? 1'b0 : tx_ser;
    assign rts = ctrl_q[B_CTS];
endmodule

// File: rtl/regbus_uart_chk.sv
// Property checker for regbus_uart, attached by bind below.
// Assumes the status and control bit positions of the package.
module regbus_uart_chk
    import regbus_uart_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [STAT_W-1:0] stat_vec,
    input logic [STAT_W-1:0] ctrl_q,
    input logic              rx_done,
    input logic              irq,
    input logic              txd
);
    logic at_rx, at_tx, at_stat;
    assign at_rx   = (bus_addr == 5'h00);
    assign at_tx   = (bus_addr == 5'h04);
    assign at_stat = (bus_addr == 5'h08);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec[B_TEMP] && !ctrl_q[B_TBRK]) |-> txd); // R4
    AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[B_TBRK] |-> !txd); // R12
    AST_TX_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_tx && !stat_vec[B_TRDY]) |=> stat_vec[B_TOVR]); // R5
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_rx && !rx_done) |=> !stat_vec[B_RRDY]); // R6
    AST_RX_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && stat_vec[B_RRDY] && !(bus_rd && at_rx)) |=> stat_vec[B_ROVR]); // R7
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_stat && !rx_done) |=>
        (!stat_vec[B_FRM] && !stat_vec[B_BRK] && !stat_vec[B_ROVR] && !stat_vec[B_TOVR])); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == '0) |-> !irq); // R11
endmodule

bind regbus_uart regbus_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .stat_vec(stat_vec), .ctrl_q(ctrl_q),
    .rx_done(rx_done), .irq(irq), .txd(txd)
);

// File: tb/regbus_uart_bench.sv
// Bench for regbus_uart: full 256-value sweeps in both directions plus corner cases.
module regbus_uart_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, txd, rts;
    logic        rxd = 1'b1;
    logic        cts = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cur_div = 16;
    bit mon_en = 1'b1;
    int mon_cnt = 0;
    logic [7:0] mon_data [0:511];
    logic [31:0] v;

    always #4 clk = ~clk;

    regbus_uart u_regbus_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .txd(txd), .rxd(rxd), .rts(rts), .cts(cts)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (cur_div) @(negedge clk);
        end
        rxd = stop;
        repeat (cur_div) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_tx_empty();
        logic [31:0] s;
        s = '0;
        while (s[5] !== 1'b1) bus_read(5'h08, s);
        repeat (cur_div) @(negedge clk);
    endtask

    // Line monitor: decodes transmitted frames at mid-bit (R3).
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && txd === 1'b0) begin
                logic [7:0] b;
                repeat (cur_div / 2) @(negedge clk);
                chk_eq("R3 start bit", 32'(txd), 32'h0);
                for (int i = 0; i < 8; i++) begin
                    repeat (cur_div) @(negedge clk);
                    b[i] = txd;
                end
                repeat (cur_div) @(negedge clk);
                chk_eq("R3 stop bit", 32'(txd), 32'h1);
                mon_data[mon_cnt] = b;
                mon_cnt++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 irq", 32'(irq), 0);
        chk_eq("R1 txd", 32'(txd), 1);
        chk_eq("R1 rts", 32'(rts), 0);
        bus_read(5'h08, v); chk_eq("R1 status", v, 32'h060);
        bus_read(5'h0C, v); chk_eq("R1 control", v, 0);
        bus_read(5'h10, v); chk_eq("R1 divisor", v, 16);
        // R2 unused addresses
        bus_write(5'h14, 32'hFFFF_FFFF);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_read(5'h14, v); chk_eq("R2 read 0x14", v, 0);
        bus_read(5'h1C, v); chk_eq("R2 read 0x1C", v, 0);
        bus_read(5'h0C, v); chk_eq("R2 control untouched", v, 0);
        bus_write(5'h10, 32'd16);
        bus_read(5'h10, v); chk_eq("R2 divisor readback", v, 16);

        // R3 R4 transmit sweep over every character
        base = mon_cnt;
        for (int b = 0; b < 256; b++) begin
            v = '0;
            while (v[6] !== 1'b1) bus_read(5'h08, v);
            bus_write(5'h04, 32'(b));
        end
        wait_tx_empty();
        chk_eq("R3 frame count", 32'(mon_cnt - base), 256);
        for (int b = 0; b < 256; b++) chk_eq("R3 tx byte", 32'(mon_data[base + b]), 32'(b));

        // R4 R5 R9 transmit overrun
        base = mon_cnt;
        bus_write(5'h04, 32'h3C);
        bus_read(5'h08, v); chk_eq("R4 ready after load", 32'(v[6]), 1);
        bus_write(5'h04, 32'hC3);
        bus_read(5'h08, v);
        chk_eq("R4 ready low when held", 32'(v[6]), 0);
        chk_eq("R4 empty low when busy", 32'(v[5]), 0);
        bus_write(5'h04, 32'h77);
        bus_read(5'h08, v);
        chk_eq("R5 tx overrun flag", 32'(v[4]), 1);
        chk_eq("R9 exception", 32'(v[8]), 1);
        wait_tx_empty();
        chk_eq("R5 dropped write count", 32'(mon_cnt - base), 2);
        chk_eq("R5 first", 32'(mon_data[base]), 32'h3C);
        chk_eq("R5 second", 32'(mon_data[base + 1]), 32'hC3);
        bus_write(5'h08, 0);
        bus_read(5'h08, v); chk_eq("R10 clear after tx overrun", v & 32'h51F, 0);

        // R3 divisor clamp
        bus_write(5'h10, 32'd2);
        cur_div = 4;
        base = mon_cnt;
        bus_write(5'h04, 32'hA5);
        wait_tx_empty();
        chk_eq("R3 clamp count", 32'(mon_cnt - base), 1);
        chk_eq("R3 clamp byte", 32'(mon_data[base]), 32'hA5);
        bus_write(5'h10, 32'd16);
        cur_div = 16;

        // R6 receive sweep over every character
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b1);
            bus_read(5'h08, v);
            chk_eq("R6 ready and clean", {v[7], v[4:0]}, 32'h20);
            bus_read(5'h00, v);
            chk_eq("R6 rx byte", v, 32'(b));
        end
        bus_read(5'h08, v); chk_eq("R6 ready cleared by read", 32'(v[7]), 0);

        // R7 R9 receive overrun
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        bus_read(5'h08, v);
        chk_eq("R7 rx overrun flag", 32'(v[3]), 1);
        chk_eq("R9 exception on rx overrun", 32'(v[8]), 1);
        chk_eq("R9 parity never set", 32'(v[0]), 0);
        bus_read(5'h00, v); chk_eq("R7 newer char kept", v, 32'h22);
        bus_write(5'h08, 0);
        bus_read(5'h08, v); chk_eq("R10 sticky and summary cleared", v & 32'h51F, 0);

        // R8 framing error and break
        send_frame(8'h5A, 1'b0);
        bus_read(5'h08, v);
        chk_eq("R8 framing", 32'(v[1]), 1);
        chk_eq("R8 no break", 32'(v[2]), 0);
        bus_read(5'h00, v); chk_eq("R8 framed char", v, 32'h5A);
        bus_write(5'h08, 0);
        send_frame(8'h00, 1'b0);
        bus_read(5'h08, v);
        chk_eq("R8 break", 32'(v[2]), 1);
        chk_eq("R8 break framing", 32'(v[1]), 1);
        chk_eq("R9 exception on break", 32'(v[8]), 1);
        bus_read(5'h00, v);
        bus_write(5'h08, 0);
        bus_read(5'h08, v); chk_eq("R10 break cleared", v & 32'h51F, 0);

        // R11 interrupt combine
        bus_write(5'h0C, 32'h080);
        #1 chk_eq("R11 rx enable idle", 32'(irq), 0);
        send_frame(8'h42, 1'b1);
        chk_eq("R11 irq on rx ready", 32'(irq), 1);
        bus_read(5'h00, v);
        #1 chk_eq("R11 irq drops after read", 32'(irq), 0);
        bus_write(5'h0C, 32'h040);
        #1 chk_eq("R11 irq on tx ready", 32'(irq), 1);
        bus_write(5'h0C, 0);
        #1 chk_eq("R11 control zero", 32'(irq), 0);

        // R13 CTS level and change
        cts = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(5'h08, v);
        chk_eq("R13 cts level", 32'(v[11]), 1);
        chk_eq("R13 cts change", 32'(v[10]), 1);
        bus_write(5'h08, 0);
        bus_read(5'h08, v);
        chk_eq("R10 change cleared", 32'(v[10]), 0);
        chk_eq("R13 level kept", 32'(v[11]), 1);
        bus_write(5'h0C, 32'h800);
        #1 chk_eq("R11 bit 11 not an enable", 32'(irq), 0);
        chk_eq("R12 rts driven", 32'(rts), 1);
        bus_write(5'h0C, 32'h400);
        cts = 1'b0;
        repeat (6) @(negedge clk);
        chk_eq("R13 irq on cts change", 32'(irq), 1);
        bus_write(5'h08, 0);
        #1 chk_eq("R10 irq drops after clear", 32'(irq), 0);

        // R12 forced break on the transmit line
        mon_en = 1'b0;
        bus_write(5'h0C, 32'h200);
        #1 chk_eq("R12 break forces low", 32'(txd), 0);
        chk_eq("R12 rts low", 32'(rts), 0);
        bus_write(5'h0C, 0);
        #1 chk_eq("R12 line released", 32'(txd), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule